// File: doc/BRIEF.md
# Cascadable Dual 16-bit Timer/Counter

This block holds two 16-bit timer/counters. A single mode bit in a configuration register can join them into one 32-bit timer or 32-bit event counter. In the joined mode the low timer holds count bits 15:0 and the high timer holds bits 31:16. The carry out of the low half feeds the high half. Only the high overflow flag reports the 32-bit wrap.

Counting is paced by a machine-cycle strobe `cyc_en`, which pulses once per 12 oscillator periods. In event mode, each timer instead counts falling edges on its external input. Those edges are found by sampling the input on successive strobes. Software loads each count byte, the configuration register and a control register through one byte-wide write port. When the joined mode is off, each timer is a plain 16-bit counter gated by its own run bit.

Top module: `chain_tmr32`

## Requirements
- R1: After a synchronous active-low reset, `count` is zero, both overflow flags are 0 and every configuration and control bit is 0.
- R2: A write to address 0/1/2/3 loads `count` bits 7:0 / 15:8 / 23:16 / 31:24. A written byte takes the written value even when an increment of that byte falls in the same cycle.
- R3: With configuration bit 6 set (write address 4) and control bit 2 clear, `count` advances by one as a 32-bit value on every cycle with `cyc_en` high. This does not depend on the run bits.
- R4: In joined mode the low half rolling from 0xFFFF to 0 increments the high half and leaves `ovf_lo` unchanged.
- R5: In joined mode, `count` advancing from 0xFFFFFFFF wraps to 0 with no reload and sets `ovf_hi` on the same clock edge.
- R6: In joined mode with control bit 2 set, `count` advances once per falling edge of `ext_evt[0]`. An edge is a 1 sampled on one `cyc_en` strobe followed by a 0 on the next strobe. The count moves on the strobe after the 0 sample, and an input held steady does not count.
- R7: Clearing configuration bit 6 stops the joined count. Each half then counts only if its own run bit is set: control bit 0 for the low half, bit 1 for the high half.
- R8: With joined mode off, a running half wraps from 0xFFFF to 0 on its own, sets its own flag (`ovf_lo` or `ovf_hi`) and does not carry into the other half.
- R9: The overflow flags stay set until a write to the control register (address 5), which loads `ovf_lo` from data bit 4 and `ovf_hi` from bit 5.
- R10: Nothing counts on a cycle with `cyc_en` low.
- R11: Configuration bits other than bit 6, including bit 7 (watchdog enable), have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle strobe |
| ext_evt | input | 2 | External event inputs, bit 0 for the low timer, bit 1 for the high timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0-3 count bytes, 4 configuration, 5 control |
| wr_data | input | 8 | Write data |
| count | output | 32 | Current value, high timer in bits 31:16 |
| ovf_lo | output | 1 | Low timer overflow flag |
| ovf_hi | output | 1 | High timer / 32-bit overflow flag |

## Verification
Count, byte writes and flag updates all land on the clock edge that closes the strobe or write cycle. The bench therefore drives on the falling edge and reads one falling edge later. Write cycles keep `cyc_en` low, so the expected value after a write plus N strobes is the written value plus N. The exception is event mode, which adds two strobes of latency through the input samplers. There the bench expects the step on the second strobe after the input drops and checks that no further step follows.

// File: rtl/ctm_pkg.sv
// Package: shared register addresses and bit positions for the cascadable
// timer pair. Assumes a byte-wide write port with a 3-bit address.
package ctm_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_T0L = 3'd0,
        A_T0H = 3'd1,
        A_T1L = 3'd2,
        A_T1H = 3'd3,
        A_CFG = 3'd4,
        A_CTL = 3'd5
    } reg_addr_e;

    localparam int CFG_CHAIN_BIT = 6;
    localparam int CTL_RUN0 = 0;
    localparam int CTL_RUN1 = 1;
    localparam int CTL_SEL0 = 2;
    localparam int CTL_SEL1 = 3;
    localparam int CTL_FLG0 = 4;
    localparam int CTL_FLG1 = 5;
endpackage

// File: rtl/ctm_fall_det.sv
// Module: falling-edge detector for an external event input.
// Samples din on each strobe. The fall output is high while the older sample
// is 1 and the newer sample is 0. Assumes din is already synchronous to clk.
module ctm_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic din,
    output logic fall
);
    logic smp_new;
    logic smp_old;

    // Shift the input through two strobe-qualified samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_new <= 1'b0;
            smp_old <= 1'b0;
        end else if (strobe) begin
            smp_old <= smp_new;
            smp_new <= din;
        end
    end

    assign fall = smp_old & ~smp_new;
endmodule

// File: rtl/ctm_half.sv
// Module: one W-bit count register with byte-granular load.
// Adds inc each cycle. A byte being written takes the written data instead
// of its incremented value. Assumes W is a multiple of 8.
module ctm_half #(
    parameter int W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic [W/8-1:0]     wr_sel,
    input  logic [7:0]         wr_data,
    output logic [W-1:0]       cnt,
    output logic               at_max
);
    localparam int BYTES = W / 8;

    logic [W-1:0] nxt;

    // Incremented value of the whole half.
    always_comb nxt = cnt + {{(W-1){1'b0}}, inc};

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        // Per-byte register: load wins over increment.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt[b*8 +: 8] <= 8'h00;
            else if (wr_sel[b])
                cnt[b*8 +: 8] <= wr_data;
            else
                cnt[b*8 +: 8] <= nxt[b*8 +: 8];
        end
    end

    assign at_max = &cnt;
endmodule

// File: rtl/chain_tmr32.sv
// Module: two 16-bit timer/counters that one mode bit can join into a
// 32-bit timer or event counter. The low half feeds its carry into the high
// half without raising its own flag. Assumes cyc_en pulses once per machine
// cycle and that ext_evt is synchronous to clk.
module chain_tmr32 #(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cyc_en,
    input  logic [1:0]          ext_evt,
    input  logic                wr_en,
    input  logic [2:0]          wr_addr,
    input  logic [7:0]          wr_data,
    output logic [2*HALF_W-1:0] count,
    output logic                ovf_lo,
    output logic                ovf_hi
);
    import ctm_pkg::*;

    localparam int NB = HALF_W / 8;

    logic        chain_on;
    logic [1:0]  run_q;
    logic [1:0]  sel_q;
    logic        ev_sel0;
    logic [1:0]  fall;
    logic [1:0]  src_ok;
    logic        inc0;
    logic        inc1;
    logic        max0;
    logic        max1;
    logic [HALF_W-1:0] cnt0;
    logic [HALF_W-1:0] cnt1;
    logic [NB-1:0] wsel0;
    logic [NB-1:0] wsel1;
    logic        wr_cfg;
    logic        wr_ctl;

    assign ev_sel0 = sel_q[0];

    // Decode the write address into per-register strobes.
    always_comb begin
        wr_cfg = wr_en && (wr_addr == A_CFG);
        wr_ctl = wr_en && (wr_addr == A_CTL);
        for (int i = 0; i < NB; i++) begin
            wsel0[i] = wr_en && (wr_addr == 3'(i));
            wsel1[i] = wr_en && (wr_addr == 3'(NB + i));
        end
    end

    // Hold the join-mode bit; the other configuration bits have no function.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_on <= 1'b0;
        else if (wr_cfg)
            chain_on <= wr_data[CFG_CHAIN_BIT];
    end

    // Hold the run and source-select bits of both halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 2'b00;
            sel_q <= 2'b00;
        end else if (wr_ctl) begin
            run_q <= {wr_data[CTL_RUN1], wr_data[CTL_RUN0]};
            sel_q <= {wr_data[CTL_SEL1], wr_data[CTL_SEL0]};
        end
    end

    for (genvar t = 0; t < 2; t++) begin : g_evt
        ctm_fall_det u_fd (
            .clk    (clk),
            .rst_n  (rst_n),
            .strobe (cyc_en),
            .din    (ext_evt[t]),
            .fall   (fall[t])
        );
        assign src_ok[t] = sel_q[t] ? fall[t] : 1'b1;
    end

    // Count enables: the joined mode overrides run bits and chains the carry.
    always_comb begin
        inc0 = cyc_en && (chain_on || run_q[0]) && src_ok[0];
        if (chain_on)
            inc1 = inc0 && max0;
        else
            inc1 = cyc_en && run_q[1] && src_ok[1];
    end

    ctm_half #(.W(HALF_W)) u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc0),
        .wr_sel  (wsel0),
        .wr_data (wr_data),
        .cnt     (cnt0),
        .at_max  (max0)
    );

    ctm_half #(.W(HALF_W)) u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (inc1),
        .wr_sel  (wsel1),
        .wr_data (wr_data),
        .cnt     (cnt1),
        .at_max  (max1)
    );

    // Sticky overflow flags; a control write loads them directly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_lo <= 1'b0;
            ovf_hi <= 1'b0;
        end else if (wr_ctl) begin
            ovf_lo <= wr_data[CTL_FLG0];
            ovf_hi <= wr_data[CTL_FLG1];
        end else begin
            if (inc0 && max0 && !chain_on)
                ovf_lo <= 1'b1;
            if (inc1 && max1)
                ovf_hi <= 1'b1;
        end
    end

    assign count = {cnt1, cnt0};
endmodule

// File: rtl/chain_tmr32_chk.sv
// Module: property checker for chain_tmr32, attached by bind below.
// Assumes the write addresses of ctm_pkg.
module chain_tmr32_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_en,
    input logic         wr_en,
    input logic [2:0]   wr_addr,
    input logic [7:0]   wr_data,
    input logic         chain_on,
    input logic         ev_sel0,
    input logic [W-1:0] count,
    input logic         ovf_lo,
    input logic         ovf_hi
);
    logic ctl_wr;
    assign ctl_wr = wr_en && (wr_addr == 3'd5);

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_on && cyc_en && !ev_sel0 && !wr_en && count != '1)
        |=> count == $past(count) + W'(1));

    assert_lo_flag_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_on && !ctl_wr) |=> !$rose(ovf_lo));

    assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_on && cyc_en && !ev_sel0 && !wr_en && count == '1)
        |=> (count == '0 && ovf_hi));

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_hi && !ctl_wr) |=> ovf_hi);

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !wr_en) |=> $stable(count));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> count[7:0] == $past(wr_data));
endmodule

bind chain_tmr32 chain_tmr32_chk #(.W(2*HALF_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .chain_on (chain_on),
    .ev_sel0  (ev_sel0),
    .count    (count),
    .ovf_lo   (ovf_lo),
    .ovf_hi   (ovf_hi)
);

// File: tb/chain_tmr32_test.sv
// Bench: a vector table of write / strobe-count / expected-state steps,
// then directed tests for reset, load priority, strobe gaps and event mode.
module chain_tmr32_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_en = 1'b0;
    logic [1:0]  ext_evt = 2'b11;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [7:0]  wr_data = 8'h00;
    logic [31:0] count;
    logic        ovf_lo;
    logic        ovf_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_tmr32 uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_en  (cyc_en),
        .ext_evt (ext_evt),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count   (count),
        .ovf_lo  (ovf_lo),
        .ovf_hi  (ovf_hi)
    );

    // Vector: {addr[2:0], data[7:0], strobes[7:0], exp_count[31:0], exp_flags{hi,lo}}
    localparam logic [52:0] VEC [NVEC] = '{
        {3'd5, 8'h00, 8'd0, 32'h0000_0000, 2'b00}, // R9 clear
        {3'd0, 8'hFD, 8'd0, 32'h0000_00FD, 2'b00}, // R2
        {3'd1, 8'hFF, 8'd0, 32'h0000_FFFD, 2'b00}, // R2
        {3'd4, 8'h40, 8'd5, 32'h0001_0002, 2'b00}, // R3 R4
        {3'd2, 8'hFF, 8'd0, 32'h00FF_0002, 2'b00}, // R2
        {3'd3, 8'hFF, 8'd0, 32'hFFFF_0002, 2'b00}, // R2
        {3'd0, 8'hFE, 8'd0, 32'hFFFF_00FE, 2'b00}, // R2
        {3'd1, 8'hFF, 8'd0, 32'hFFFF_FFFE, 2'b00}, // R2
        {3'd4, 8'hC0, 8'd3, 32'h0000_0001, 2'b10}, // R5
        {3'd5, 8'h00, 8'd2, 32'h0000_0003, 2'b00}, // R9
        {3'd4, 8'h00, 8'd4, 32'h0000_0003, 2'b00}, // R7 stop
        {3'd4, 8'hBF, 8'd4, 32'h0000_0003, 2'b00}, // R11
        {3'd5, 8'h01, 8'd4, 32'h0000_0007, 2'b00}, // R7 run0 continues
        {3'd0, 8'hFE, 8'd0, 32'h0000_00FE, 2'b00}, // R2
        {3'd1, 8'hFF, 8'd0, 32'h0000_FFFE, 2'b00}, // R2
        {3'd5, 8'h01, 8'd3, 32'h0000_0001, 2'b01}, // R8 low wrap
        {3'd5, 8'h02, 8'd2, 32'h0002_0001, 2'b00}, // R8 high alone
        {3'd5, 8'h10, 8'd2, 32'h0002_0001, 2'b01}  // R9 flag set by write
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R9";
            3: return "R3/R4";
            8: return "R5";
            9: return "R9";
            10: return "R7";
            11: return "R11";
            12: return "R7";
            15: return "R8";
            16: return "R8";
            17: return "R9";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual count/flags %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cyc_en = 1'b0;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_en = 1'b1;
            @(negedge clk);
        end
        cyc_en = 1'b0;
    endtask

    function automatic logic [33:0] state();
        return {count, ovf_hi, ovf_lo};
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset", state(), 34'h0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][52:50], VEC[i][49:42]);
            strobes(int'(VEC[i][41:34]));
            check(vec_req(i), state(), VEC[i][33:0]);
        end

        // R1: reset mid-run returns everything to zero
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        strobes(3);
        check("R1 reset/no run", state(), 34'h0);

        // R2: load wins over increment in the same cycle
        do_write(3'd4, 8'h40);
        @(negedge clk);
        cyc_en = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h55;
        @(negedge clk);
        wr_en = 1'b0; cyc_en = 1'b0;
        check("R2 priority", state(), {32'h0000_0055, 2'b00});
        strobes(1);
        check("R3 step", state(), {32'h0000_0056, 2'b00});

        // R10: gaps in the strobe stop counting
        cyc_en = 1'b1; @(negedge clk);
        cyc_en = 1'b0; @(negedge clk);
        @(negedge clk);
        cyc_en = 1'b1; @(negedge clk);
        cyc_en = 1'b0;
        check("R10 gaps", state(), {32'h0000_0058, 2'b00});

        // R6: event mode counts one falling edge per 1-then-0 sample pair
        ext_evt[0] = 1'b1;
        do_write(3'd5, 8'h04);
        strobes(4);
        check("R6 steady high", state(), {32'h0000_0058, 2'b00});
        ext_evt[0] = 1'b0;
        strobes(1);
        check("R6 not yet", state(), {32'h0000_0058, 2'b00});
        strobes(1);
        check("R6 one edge", state(), {32'h0000_0059, 2'b00});
        strobes(4);
        check("R6 steady low", state(), {32'h0000_0059, 2'b00});
        ext_evt[0] = 1'b1;
        strobes(2);
        ext_evt[0] = 1'b0;
        strobes(3);
        check("R6 second edge", state(), {32'h0000_005A, 2'b00});

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule